// File: doc/BRIEF.md
# Prioritizing Interrupt Controller

This block gathers level-sensitive interrupt request lines, 96 by default or 128 as an alternative, arranged in banks of 32. It picks the single most urgent request and raises one interrupt output toward a processor. Software drives it through a small register space on a 32-bit word bus. Each bank has a mask register with write-one set and write-one clear aliases, plus a read-only pending view. Each source has a priority level register. A global threshold filters out sources that are not urgent enough.

When a request is eligible, a sorting engine watches the candidates over a fixed window of clock cycles before it commits to a result. The processor then reads the active-interrupt register to learn the source number. If the winning source went away during the window, or the outcome moved during the window, the result is marked invalid rather than reported. The processor acknowledges through the control register, and that ack lets the next sort begin.

Around the sorter sit a soft-reset handshake, a protection bit that locks out user-mode writes, a revision register, and storage for the autoidle and idle-mode bits.

Top module: `intc_top`

## Requirements
- R1: After reset, every source is masked: mask reads 0xFFFFFFFF, pending reads 0, and level registers read 0. The threshold reads 0xFF, the status register (0x14) bit 0 reads 1, the revision register (0x00) reads 0x40 (major in bits [7:4], minor in [3:0]), irq_out is 0, and the active register (0x40) reads 0xFFFFFF80.
- R2: Each bank b has registers at offsets 0x20·b from the bases below:
  - mask at 0x84, which is directly writable; a set bit blocks the source;
  - a clear alias at 0x88, where writing 1 to a bit clears that mask bit;
  - a set alias at 0x8C, where writing 1 to a bit sets that mask bit.
  Zero bits written to the aliases leave the mask unchanged, and all three addresses read back the mask.
- R3: The pending register at 0x98 + 0x20·b reads the bank's request lines ANDed with the inverse of its mask.
- R4: The level register for source i sits at 0x100 + 4·i and holds a 6-bit priority in bits [7:2]; the other bits read 0. Priority 0 is the most urgent. Among eligible sources the lowest priority value wins, and on a tie the lower source number wins.
- R5: A source is eligible only if it is pending and unmasked and its priority is strictly less than the threshold register (0x68, bits [7:0]). A priority equal to the threshold is not eligible.
- R6: The block samples requests at clock edges. Count as edge 1 the first edge at which an eligible request is present. irq_out rises at edge 10. For a valid result, the active register then reads the winning number in bits [6:0] and zeros in bits [31:7].
- R7: If, during the sort window, the captured winner stops being eligible or a different source becomes the winner, the result is spurious. irq_out still rises, and active register bits [31:7] read all ones.
- R8: Writing 1 to bit 0 of the control register (0x48) while irq_out is high drops irq_out at the next edge. A still-eligible request then starts a new sort, and irq_out rises again 10 edges after the ack edge.
- R9: Writing 1 to bit 1 of sysconfig (0x10) returns every register to its R1 value. Status bit 0 reads 0 for 4 edges, and writes made while it reads 0 are ignored.
- R10: When protection (0x4C, bit 0) is 1, writes with bus_user high are ignored, including writes to the protection register itself. Writes with bus_user low still take effect.
- R11: Sysconfig bit 0 (autoidle) and idle register (0x50) bits [1:0] (functional idle, turbo) are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Level-sensitive request lines |
| bus_we | input | 1 | Write strobe, one word per edge |
| bus_user | input | 1 | Write comes from user mode |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Sort result held, waiting for ack |

## Verification
A corrupted mask or level bit shows up on the first sort that involves that source: the active register names the wrong number, or irq_out fails to rise within 10 edges. A sorter stuck in its window or stuck holding a result shows up as irq_out missing its exact rise edge, or not dropping on the edge after an ack. A soft-reset counter that is off by one moves the edge at which status bit 0 returns to 1. It also lets a write during the busy period land, and the threshold readback then exposes that write immediately.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    typedef enum logic [1:0] {S_IDLE, S_SORT, S_HOLD} sort_st_e;

    localparam logic [11:0] A_REV  = 12'h000;
    localparam logic [11:0] A_SYSC = 12'h010;
    localparam logic [11:0] A_SYSS = 12'h014;
    localparam logic [11:0] A_ACT  = 12'h040;
    localparam logic [11:0] A_CTRL = 12'h048;
    localparam logic [11:0] A_PROT = 12'h04C;
    localparam logic [11:0] A_IDLE = 12'h050;
    localparam logic [11:0] A_THR  = 12'h068;
    localparam logic [11:0] A_BANK = 12'h080;
    localparam logic [11:0] A_LVL  = 12'h100;

    localparam logic [4:0] B_MASK = 5'h04;
    localparam logic [4:0] B_CLR  = 5'h08;
    localparam logic [4:0] B_SET  = 5'h0C;
    localparam logic [4:0] B_PEND = 5'h18;
endpackage

// File: rtl/intc_pick.sv
`timescale 1ns/1ps
module intc_pick #(
    parameter int NSRC = 96,
    parameter int IW   = 7
) (
    input  logic [NSRC-1:0]   req,
    input  logic [NSRC*6-1:0] lvl_flat,
    input  logic [7:0]        thr,
    output logic              hit,
    output logic [IW-1:0]     idx
);
    logic [5:0] best;
    logic [5:0] p;

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = 6'h3f;
        p    = '0;
        for (int i = 0; i < NSRC; i++) begin
            p = lvl_flat[i*6 +: 6];
            // strict compare keeps the lower index on a tie
            if (req[i] && ({2'b00, p} < thr) && (!hit || p < best)) begin
                hit  = 1'b1;
                best = p;
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_sort.sv
`timescale 1ns/1ps
module intc_sort
    import intc_pkg::*;
#(
    parameter int SORT_CYCLES = 10,
    parameter int IW          = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    input  logic          ack,
    output logic          hold,
    output logic [IW-1:0] res_idx,
    output logic          res_spur
);
    localparam int CW = $clog2(SORT_CYCLES);

    typedef struct packed {
        sort_st_e      st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] cap;
        logic          spur;
    } sort_t;

    sort_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: if (hit) begin
                s_d.st   = S_SORT;
                s_d.cnt  = CW'(SORT_CYCLES - 2);
                s_d.cap  = idx;
                s_d.spur = 1'b0;
            end
            S_SORT: begin
                if (!hit || idx != s_q.cap) s_d.spur = 1'b1;
                if (s_q.cnt == '0) s_d.st = S_HOLD;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            S_HOLD: if (ack) s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
        if (clr) s_d = '{st: S_IDLE, cnt: '0, cap: '0, spur: 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, cnt: '0, cap: '0, spur: 1'b0};
        else        s_q <= s_d;
    end

    assign hold     = (s_q.st == S_HOLD);
    assign res_idx  = s_q.cap;
    assign res_spur = s_q.spur;
endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
    import intc_pkg::*;
#(
    parameter int         NSRC        = 96,
    parameter int         SORT_CYCLES = 10,
    parameter int         RST_CYCLES  = 4,
    parameter logic [3:0] REV_MAJOR   = 4'd4,
    parameter logic [3:0] REV_MINOR   = 4'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_we,
    input  logic            bus_user,
    input  logic [11:0]     bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq_out
);
    localparam int NBANK = NSRC / 32;
    localparam int IW    = 7;
    localparam int SW    = $clog2(NSRC);
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int RCW   = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic                 autoidle;
        logic [1:0]           idle;
        logic                 prot;
        logic [7:0]           thr;
        logic [NSRC-1:0]      mask;
        logic [NSRC-1:0][5:0] lvl;
        logic [RCW-1:0]       rcnt;
    } regs_t;

    regs_t r_d, r_q;

    logic                  wr_ok, ack_go, srst_go, sts_done;
    logic                  in_bank, in_lvl;
    logic [6:0]            boff;
    logic [9:0]            loff;
    logic [BW-1:0]         bidx;
    logic [SW-1:0]         bstart, lsel;
    logic [NBANK-1:0][31:0] bank_pend;
    logic                  hit, res_spur;
    logic [IW-1:0]         win_idx, res_idx;
    logic                  prot_q;
    logic [7:0]            thr_q;

    genvar gb;
    for (gb = 0; gb < NBANK; gb++) begin : g_pend
        assign bank_pend[gb] = irq_in[gb*32 +: 32] & ~r_q.mask[gb*32 +: 32];
    end

    always_comb begin
        sts_done = (r_q.rcnt == '0);
        wr_ok    = bus_we && sts_done && !(r_q.prot && bus_user);
        ack_go   = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
        srst_go  = wr_ok && (bus_addr == A_SYSC) && bus_wdata[1];
        in_bank  = (bus_addr >= A_BANK) && (bus_addr < A_BANK + 12'(NBANK * 32));
        in_lvl   = (bus_addr >= A_LVL) && (bus_addr < A_LVL + 12'(NSRC * 4))
                   && (bus_addr[1:0] == 2'b00);
        boff     = bus_addr[11:5] - 7'h04;
        loff     = bus_addr[11:2] - 10'h040;
        bidx     = BW'(boff);
        bstart   = SW'({boff, 5'd0});
        lsel     = SW'(loff);
    end

    always_comb begin
        r_d = r_q;
        if (r_q.rcnt != '0) r_d.rcnt = r_q.rcnt - 1'b1;
        if (wr_ok) begin
            case (bus_addr)
                A_SYSC:  r_d.autoidle = bus_wdata[0];
                A_IDLE:  r_d.idle     = bus_wdata[1:0];
                A_PROT:  r_d.prot     = bus_wdata[0];
                A_THR:   r_d.thr      = bus_wdata[7:0];
                default: ;
            endcase
            if (in_bank) begin
                case (bus_addr[4:0])
                    B_MASK:  r_d.mask[bstart +: 32] = bus_wdata;
                    B_CLR:   r_d.mask[bstart +: 32] = r_q.mask[bstart +: 32] & ~bus_wdata;
                    B_SET:   r_d.mask[bstart +: 32] = r_q.mask[bstart +: 32] | bus_wdata;
                    default: ;
                endcase
            end
            if (in_lvl) r_d.lvl[lsel] = bus_wdata[7:2];
        end
        if (srst_go) begin
            r_d          = '0;
            r_d.thr      = 8'hFF;
            r_d.mask     = '1;
            r_d.rcnt     = RCW'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.thr  <= 8'hFF;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    intc_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
        .req      (irq_in & ~r_q.mask),
        .lvl_flat (r_q.lvl),
        .thr      (r_q.thr),
        .hit      (hit),
        .idx      (win_idx)
    );

    intc_sort #(.SORT_CYCLES(SORT_CYCLES), .IW(IW)) u_sort (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (srst_go),
        .hit      (hit),
        .idx      (win_idx),
        .ack      (ack_go),
        .hold     (irq_out),
        .res_idx  (res_idx),
        .res_spur (res_spur)
    );

    assign prot_q = r_q.prot;
    assign thr_q  = r_q.thr;

    always_comb begin
        bus_rdata = '0;
        if (in_bank) begin
            if (bus_addr[4:0] == B_PEND) bus_rdata = bank_pend[bidx];
            else if (bus_addr[4:0] == B_MASK || bus_addr[4:0] == B_CLR ||
                     bus_addr[4:0] == B_SET) bus_rdata = r_q.mask[bstart +: 32];
        end else if (in_lvl) begin
            bus_rdata = {24'd0, r_q.lvl[lsel], 2'b00};
        end else begin
            case (bus_addr)
                A_REV:   bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
                A_SYSC:  bus_rdata = {31'd0, r_q.autoidle};
                A_SYSS:  bus_rdata = {31'd0, sts_done};
                A_ACT:   bus_rdata = (irq_out && !res_spur) ? {25'd0, res_idx}
                                   : {25'h1FFFFFF, (irq_out ? res_idx : 7'd0)};
                A_PROT:  bus_rdata = {31'd0, r_q.prot};
                A_IDLE:  bus_rdata = {30'd0, r_q.idle};
                A_THR:   bus_rdata = {24'd0, r_q.thr};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_top_chk.sv
`timescale 1ns/1ps
module intc_top_chk #(
    parameter int NSRC = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_out,
    input logic       bus_we,
    input logic       bus_user,
    input logic       ack_go,
    input logic       srst_go,
    input logic       sts_done,
    input logic       prot_q,
    input logic [7:0] thr_q,
    input logic       res_spur,
    input logic [6:0] res_idx
);
    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !ack_go && !srst_go |=> irq_out);
    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && ack_go |=> !irq_out);
    // R9
    srst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_go |=> !sts_done);
    // R10
    prot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q && bus_we && bus_user |=> $stable(thr_q));
    // R6
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !res_spur |-> int'(res_idx) < NSRC);
endmodule

bind intc_top intc_top_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .bus_we   (bus_we),
    .bus_user (bus_user),
    .ack_go   (ack_go),
    .srst_go  (srst_go),
    .sts_done (sts_done),
    .prot_q   (prot_q),
    .thr_q    (thr_q),
    .res_spur (res_spur),
    .res_idx  (res_idx)
);

// File: tb/intc_top_test.sv
`timescale 1ns/1ps
module intc_top_test;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic            bus_we = 1'b0, bus_user = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int errors = 0, checks = 0;
    logic [NSRC-1:0] m_mask;
    int m_lvl [NSRC];
    int m_thr;

    intc_top uut (.*);

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic user = 1'b0);
        bus_addr = a; bus_wdata = d; bus_user = user; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_user = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lvl(input int i, input int p);
        m_lvl[i] = p;
        wr(12'(12'h100 + 4 * i), 32'(p << 2));
    endtask

    task automatic set_mask(input int b, input logic [31:0] v);
        m_mask[b*32 +: 32] = v;
        wr(12'(12'h084 + 32 * b), v);
    endtask

    task automatic set_thr(input int t);
        m_thr = t;
        wr(12'h068, 32'(t));
    endtask

    function automatic int exp_win(input logic [NSRC-1:0] req);
        int w = -1;
        int bp = 64;
        for (int i = 0; i < NSRC; i++)
            if (req[i] && !m_mask[i] && m_lvl[i] < m_thr && m_lvl[i] < bp) begin
                w = i; bp = m_lvl[i];
            end
        return w;
    endfunction

    // hold req for exactly 10 edges, read the result, then release and ack
    task automatic sort_once(input logic [NSRC-1:0] req, output logic [31:0] act, output logic held);
        irq_in = req;
        edges(10);
        held = irq_out;
        rd(12'h040, act);
        irq_in = '0;
        wr(12'h048, 32'h1);
    endtask

    logic [31:0] d;
    logic        h;

    initial begin
        void'($urandom(32'h1234));
        m_mask = '1; m_thr = 255;
        for (int i = 0; i < NSRC; i++) m_lvl[i] = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, d); check("R1 revision", d, 32'h40);
        rd(12'h014, d); check("R1 status", d, 32'h1);
        rd(12'h068, d); check("R1 threshold", d, 32'hFF);
        rd(12'h0C4, d); check("R1 mask bank2", d, 32'hFFFFFFFF);
        rd(12'h104, d); check("R1 level", d, 32'h0);
        rd(12'h040, d); check("R1 active", d, 32'hFFFFFF80);
        check("R1 irq_out", 32'(irq_out), 32'h0);

        // R11 stored bits
        wr(12'h010, 32'h1); rd(12'h010, d); check("R11 autoidle", d, 32'h1);
        wr(12'h050, 32'h3); rd(12'h050, d); check("R11 idle", d, 32'h3);
        wr(12'h050, 32'h2); rd(12'h050, d); check("R11 turbo only", d, 32'h2);

        // R3 pending view, masked then partly unmasked
        irq_in[31:0] = 32'h0000_000F;
        rd(12'h098, d); check("R3 pending masked", d, 32'h0);
        wr(12'h088, 32'h3);
        rd(12'h098, d); check("R3 pending unmasked", d, 32'h3);
        irq_in = '0;
        edges(12);
        wr(12'h048, 32'h1);
        wr(12'h08C, 32'h3);

        // R2 mask aliases
        wr(12'h084, 32'h0);
        rd(12'h084, d); check("R2 direct write", d, 32'h0);
        wr(12'h08C, 32'h0000_00F0);
        rd(12'h084, d); check("R2 set alias", d, 32'h0000_00F0);
        wr(12'h088, 32'h0000_0030);
        rd(12'h088, d); check("R2 clear alias", d, 32'h0000_00C0);
        rd(12'h0C4, d); check("R2 other bank untouched", d, 32'hFFFFFFFF);

        // random priorities, everything unmasked
        for (int i = 0; i < NSRC; i++) set_lvl(i, int'($urandom_range(63)));
        for (int b = 0; b < 3; b++) set_mask(b, 32'h0);
        rd(12'h114, d); check("R4 level readback", d, 32'(m_lvl[5] << 2));

        // R6 exact rise edge
        irq_in = '0; irq_in[5] = 1'b1;
        edges(9);
        check("R6 not yet at edge 9", 32'(irq_out), 32'h0);
        edges(1);
        check("R6 rises at edge 10", 32'(irq_out), 32'h1);
        rd(12'h040, d); check("R6 active number", d, 32'd5);
        irq_in = '0;
        wr(12'h048, 32'h1);
        check("R8 drop after ack", 32'(irq_out), 32'h0);

        // R4 tie and priority order
        set_lvl(10, 3); set_lvl(20, 3); set_lvl(30, 7);
        sort_once((96'd1 << 10) | (96'd1 << 20) | (96'd1 << 30), d, h);
        check("R4 tie lower index", d, 32'd10);
        set_lvl(20, 1);
        sort_once((96'd1 << 10) | (96'd1 << 20) | (96'd1 << 30), d, h);
        check("R4 more urgent wins", d, 32'd20);

        // R5 threshold boundary
        set_lvl(40, 4); set_thr(4);
        irq_in = 96'd1 << 40;
        edges(12);
        check("R5 equal not eligible", 32'(irq_out), 32'h0);
        irq_in = '0;
        set_thr(5);
        sort_once(96'd1 << 40, d, h);
        check("R5 below threshold", d, 32'd40);
        set_thr(255);

        // R7 source drops mid-window
        irq_in = 96'd1 << 50;
        edges(3);
        irq_in = '0;
        edges(7);
        check("R7 irq_out on drop", 32'(irq_out), 32'h1);
        rd(12'h040, d); check("R7 spurious on drop", d & 32'hFFFFFF80, 32'hFFFFFF80);
        wr(12'h048, 32'h1);

        // R7 mask change alters the outcome
        set_lvl(60, 2); set_lvl(61, 9);
        irq_in = (96'd1 << 60) | (96'd1 << 61);
        edges(3);
        wr(12'h0AC, 32'h1000_0000);
        m_mask[60] = 1'b1;
        edges(6);
        check("R7 irq_out on mask", 32'(irq_out), 32'h1);
        rd(12'h040, d); check("R7 spurious on mask", d & 32'hFFFFFF80, 32'hFFFFFF80);
        irq_in = '0;
        wr(12'h048, 32'h1);
        wr(12'h0A8, 32'h1000_0000);
        m_mask[60] = 1'b0;

        // R8 re-sort after ack with request still present
        irq_in = 96'd1 << 70;
        edges(10);
        wr(12'h048, 32'h1);
        check("R8 low after ack", 32'(irq_out), 32'h0);
        edges(9);
        check("R8 re-sort not early", 32'(irq_out), 32'h0);
        edges(1);
        check("R8 re-sort result", 32'(irq_out), 32'h1);
        irq_in = '0;
        wr(12'h048, 32'h1);

        // random mixes
        for (int it = 0; it < 30; it++) begin
            int w;
            logic [NSRC-1:0] req;
            for (int b = 0; b < 3; b++) set_mask(b, $urandom & $urandom);
            set_thr(($urandom_range(2) == 0) ? 255 : int'($urandom_range(63)));
            for (int b = 0; b < 3; b++) req[b*32 +: 32] = $urandom & $urandom & $urandom;
            irq_in = req;
            w = exp_win(req);
            edges(11);
            rd(12'h0B8, d); check("R3 random pending", d, req[63:32] & ~m_mask[63:32]);
            check("R5 random eligibility", 32'(irq_out), (w >= 0) ? 32'h1 : 32'h0);
            if (w >= 0) begin
                rd(12'h040, d); check("R4 random winner", d, 32'(w));
            end
            irq_in = '0;
            wr(12'h048, 32'h1);
            edges(1);
        end

        // R10 protection
        set_thr(255);
        wr(12'h04C, 32'h1);
        wr(12'h068, 32'h3, 1'b1);
        rd(12'h068, d); check("R10 user write ignored", d, 32'hFF);
        wr(12'h068, 32'h3);
        rd(12'h068, d); check("R10 privileged write", d, 32'h3);
        wr(12'h04C, 32'h0, 1'b1);
        rd(12'h04C, d); check("R10 user cannot unlock", d, 32'h1);
        wr(12'h04C, 32'h0);
        rd(12'h04C, d); check("R10 privileged unlock", d, 32'h0);

        // R9 soft reset
        set_thr(9); set_mask(0, 32'h0); set_lvl(0, 5);
        wr(12'h010, 32'h2);
        rd(12'h014, d); check("R9 busy after start", d, 32'h0);
        wr(12'h068, 32'h7);
        edges(2);
        rd(12'h014, d); check("R9 still busy", d, 32'h0);
        edges(1);
        rd(12'h014, d); check("R9 done", d, 32'h1);
        rd(12'h068, d); check("R9 threshold restored", d, 32'hFF);
        rd(12'h084, d); check("R9 masks set", d, 32'hFFFFFFFF);
        rd(12'h100, d); check("R9 level cleared", d, 32'h0);
        rd(12'h010, d); check("R9 sysconfig cleared", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule